// File: doc/BRIEF.md
# Shadowed-Period PWM Channel Counter

This block produces one pulse-width-modulated waveform from a 16-bit channel counter. The counter advances on a channel clock enable. That enable comes from the system clock divided by a power-of-two prescaler. It may then also pass through one of two integer dividers, chosen by a source select. Two counting shapes are available. In the edge-aligned shape the counter ramps up and wraps. In the symmetric shape it ramps up to the period value and back down to zero, so the same period value gives twice the waveform length.

The period is never written to the counter's compare register directly. A write lands in a staging register and raises a pending flag. The staged value moves into the active period register only at the cycle boundary, so a period change cannot cut a cycle short or stretch it. Writes are dropped while either of two protection inputs is asserted. The output is high while the counter is below the duty value.

Top module: `pwm_period_chan`

## Requirements
- R1: After a synchronous reset, `count`, `active_period`, `update_pending` and `pwm_out` are all zero.
- R2: A write made while `wp_soft` or `wp_hard` is high is dropped: `update_pending` stays low and `active_period` keeps its value.
- R3: An accepted write does not change `active_period` right away. It sets `update_pending` on the next cycle.
- R4: Only bits 15:0 of `upd_data` are kept. Bits 23:16 are discarded.
- R5: With `center_al` = 0 the counter runs 0 up to P-1 and wraps, so the waveform repeats every X*P system clocks. P is the active period and X is the total clock division.
- R6: With `center_al` = 1 the counter runs 0 up to P and back down toward zero, so the waveform repeats every 2*X*P system clocks.
- R7: The prescaler divides by 2^`pre_sel` for `pre_sel` 0 to 10. A `pre_sel` above 10 stops the counter.
- R8: `src_sel` picks the counter clock: 0 or 3 selects the prescaled clock, 1 selects the prescaled clock divided by `div_a`, and 2 selects the prescaled clock divided by `div_b`. A selected divider of zero freezes the counter.
- R9: `pwm_out` is high exactly when `count` < `duty`, in both shapes.
- R10: The staged period is transferred when the counter returns to zero. In the edge-aligned shape this is the wrap. In the symmetric shape it is the arrival at zero on the way down.
- R11: `update_pending` clears in the same cycle that the transfer occurs, and `count` is zero in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| upd_we | input | 1 | Period update write strobe |
| upd_data | input | 24 | Period update write data |
| wp_soft | input | 1 | Software protection active, blocks writes |
| wp_hard | input | 1 | Hardware protection active, blocks writes |
| pre_sel | input | 4 | Prescaler exponent |
| src_sel | input | 2 | Counter clock source select |
| div_a | input | 8 | First linear divider |
| div_b | input | 8 | Second linear divider |
| center_al | input | 1 | 1 = symmetric up/down counting |
| duty | input | 16 | Duty compare value |
| pwm_out | output | 1 | Waveform output |
| count | output | 16 | Channel counter |
| active_period | output | 16 | Period currently in force |
| update_pending | output | 1 | A staged period awaits transfer |

## Verification
The bench writes a new period partway through a cycle. A design that copied the value straight through would show the new period before the counter reached zero. The bench also checks where the symmetric transfer happens. A design that transferred at the peak, or that spent two ticks at zero or at the peak, would give waveform lengths other than 2*X*P. Writes with either protection input high must leave no pending flag behind. Prescaler values above the limit and zero divider values must freeze the count rather than wrap into some other ratio. Random mixes of prescaler, divider, source and shape are checked against the expected waveform length.

// File: rtl/pwm_chan_pkg.sv
package pwm_chan_pkg;
  typedef enum logic [1:0] {
    SRC_PRE   = 2'd0,
    SRC_DIVA  = 2'd1,
    SRC_DIVB  = 2'd2,
    SRC_PRE_B = 2'd3
  } src_sel_e;
endpackage

// File: rtl/pwm_prescaler.sv
module pwm_prescaler #(
  parameter int PRE_W   = 4,
  parameter int PRE_MAX = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [PRE_W-1:0] pre_sel,
  output logic             tick
);
  localparam int CW = (PRE_MAX > 0) ? PRE_MAX : 1;

  logic [CW-1:0] pc_q;
  logic [CW-1:0] mask;

  always_ff @(posedge clk) begin
    if (rst) pc_q <= '0;
    else     pc_q <= pc_q + CW'(1);
  end

  always_comb begin
    mask = '0;
    for (int i = 0; i < CW; i++) mask[i] = (i < int'(pre_sel));
  end

  assign tick = (int'(pre_sel) <= PRE_MAX) && ((pc_q & mask) == mask);
endmodule

// File: rtl/pwm_lin_div.sv
module pwm_lin_div #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_tick,
  input  logic [DIV_W-1:0] div,
  output logic             out_tick
);
  logic [DIV_W-1:0] dc_q;
  logic             hit;

  assign hit      = in_tick && (div != '0) && (dc_q >= div - DIV_W'(1));
  assign out_tick = hit;

  always_ff @(posedge clk) begin
    if (rst)                        dc_q <= '0;
    else if (in_tick) begin
      if (div == '0 || hit)         dc_q <= '0;
      else                          dc_q <= dc_q + DIV_W'(1);
    end
  end
endmodule

// File: rtl/pwm_period_buf.sv
module pwm_period_buf #(
  parameter int CNT_W = 16,
  parameter int UPD_W = 24
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_ok,
  input  logic [UPD_W-1:0] wr_data,
  input  logic             xfer,
  output logic [CNT_W-1:0] active,
  output logic             pending
);
  logic [CNT_W-1:0] shadow_q;
  logic             unused_hi;

  assign unused_hi = ^wr_data[UPD_W-1:CNT_W];

  always_ff @(posedge clk) begin
    if (rst) begin
      shadow_q <= '0;
      active   <= '0;
      pending  <= 1'b0;
    end else begin
      if (xfer) begin
        active  <= shadow_q;
        pending <= 1'b0;
      end
      if (wr_ok) begin
        shadow_q <= wr_data[CNT_W-1:0];
        pending  <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/pwm_chan_core.sv
module pwm_chan_core #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             center,
  input  logic [CNT_W-1:0] per,
  input  logic [CNT_W-1:0] duty,
  output logic             xfer,
  output logic [CNT_W-1:0] cnt_q,
  output logic             pwm_q
);
  localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);
  localparam logic [CNT_W:0]   ONEX = (CNT_W+1)'(1);

  logic [CNT_W-1:0] cnt_d;
  logic             up_q, up_d;

  always_comb begin
    cnt_d = cnt_q;
    up_d  = up_q;
    xfer  = 1'b0;
    if (tick) begin
      if (!center) begin
        up_d = 1'b1;
        if (({1'b0, cnt_q} + ONEX) >= {1'b0, per}) begin
          cnt_d = '0;
          xfer  = 1'b1;
        end else begin
          cnt_d = cnt_q + ONE;
        end
      end else if (up_q && (cnt_q < per)) begin
        cnt_d = cnt_q + ONE;
      end else if (cnt_q <= ONE) begin
        cnt_d = '0;
        up_d  = 1'b1;
        xfer  = 1'b1;
      end else begin
        cnt_d = cnt_q - ONE;
        up_d  = 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      up_q  <= 1'b1;
      pwm_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      up_q  <= up_d;
      pwm_q <= (cnt_d < duty);
    end
  end
endmodule

// File: rtl/pwm_period_chan.sv
module pwm_period_chan #(
  parameter int CNT_W   = 16,
  parameter int UPD_W   = 24,
  parameter int PRE_W   = 4,
  parameter int PRE_MAX = 10,
  parameter int DIV_W   = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             upd_we,
  input  logic [UPD_W-1:0] upd_data,
  input  logic             wp_soft,
  input  logic             wp_hard,
  input  logic [PRE_W-1:0] pre_sel,
  input  logic [1:0]       src_sel,
  input  logic [DIV_W-1:0] div_a,
  input  logic [DIV_W-1:0] div_b,
  input  logic             center_al,
  input  logic [CNT_W-1:0] duty,
  output logic             pwm_out,
  output logic [CNT_W-1:0] count,
  output logic [CNT_W-1:0] active_period,
  output logic             update_pending
);
  import pwm_chan_pkg::*;

  localparam int NDIV = 2;

  logic                       pre_tick;
  logic [NDIV-1:0]            div_tick;
  logic [NDIV-1:0][DIV_W-1:0] div_val;
  logic                       chan_tick;
  logic                       xfer;
  logic                       wr_ok;
  src_sel_e                   src;

  assign div_val = {div_b, div_a};
  assign src     = src_sel_e'(src_sel);
  assign wr_ok   = upd_we && !wp_soft && !wp_hard;

  pwm_prescaler #(.PRE_W(PRE_W), .PRE_MAX(PRE_MAX)) u_pre (
    .clk(clk), .rst(rst), .pre_sel(pre_sel), .tick(pre_tick)
  );

  for (genvar g = 0; g < NDIV; g++) begin : g_div
    pwm_lin_div #(.DIV_W(DIV_W)) u_div (
      .clk(clk), .rst(rst), .in_tick(pre_tick),
      .div(div_val[g]), .out_tick(div_tick[g])
    );
  end

  always_comb begin
    case (src)
      SRC_DIVA: chan_tick = div_tick[0];
      SRC_DIVB: chan_tick = div_tick[1];
      default:  chan_tick = pre_tick;
    endcase
  end

  pwm_period_buf #(.CNT_W(CNT_W), .UPD_W(UPD_W)) u_buf (
    .clk(clk), .rst(rst), .wr_ok(wr_ok), .wr_data(upd_data),
    .xfer(xfer), .active(active_period), .pending(update_pending)
  );

  pwm_chan_core #(.CNT_W(CNT_W)) u_core (
    .clk(clk), .rst(rst), .tick(chan_tick), .center(center_al),
    .per(active_period), .duty(duty), .xfer(xfer),
    .cnt_q(count), .pwm_q(pwm_out)
  );
endmodule

// File: rtl/pwm_period_chan_chk.sv
module pwm_period_chan_chk #(
  parameter int CNT_W   = 16,
  parameter int UPD_W   = 24,
  parameter int PRE_W   = 4,
  parameter int PRE_MAX = 10,
  parameter int DIV_W   = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             upd_we,
  input logic [UPD_W-1:0] upd_data,
  input logic             wp_soft,
  input logic             wp_hard,
  input logic [PRE_W-1:0] pre_sel,
  input logic [1:0]       src_sel,
  input logic [DIV_W-1:0] div_a,
  input logic [DIV_W-1:0] div_b,
  input logic             center_al,
  input logic [CNT_W-1:0] duty,
  input logic             pwm_out,
  input logic [CNT_W-1:0] count,
  input logic [CNT_W-1:0] active_period,
  input logic             update_pending
);
  logic past_ok;
  logic unused_chk;
  assign unused_chk = ^{upd_data, div_b};

  always_ff @(posedge clk) begin
    if (rst) past_ok <= 1'b0;
    else     past_ok <= 1'b1;
  end

  AST_RESET_CLEARS: assert property (@(posedge clk)
    rst |=> (count == '0 && !pwm_out && !update_pending && active_period == '0)); // R1

  AST_PROTECT_DROPS: assert property (@(posedge clk) disable iff (rst)
    (upd_we && (wp_soft || wp_hard) && !update_pending) |=> !update_pending); // R2

  AST_WRITE_PENDS: assert property (@(posedge clk) disable iff (rst)
    (upd_we && !wp_soft && !wp_hard) |=> update_pending); // R3

  AST_PERIOD_AT_ZERO: assert property (@(posedge clk) disable iff (rst)
    (past_ok && active_period != $past(active_period)) |-> (count == '0)); // R10

  AST_PENDING_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (past_ok && $fell(update_pending)) |-> (count == '0)); // R11

  AST_PWM_COMPARE: assert property (@(posedge clk) disable iff (rst)
    (past_ok && duty == $past(duty)) |-> (pwm_out == (count < duty))); // R9

  AST_PRE_INVALID_HOLD: assert property (@(posedge clk) disable iff (rst)
    (past_ok && int'($past(pre_sel)) > PRE_MAX) |-> (count == $past(count))); // R7

  AST_DIVA_ZERO_HOLD: assert property (@(posedge clk) disable iff (rst)
    (past_ok && $past(src_sel) == 2'd1 && $past(div_a) == '0) |-> (count == $past(count))); // R8

  AST_LEFT_BELOW_PERIOD: assert property (@(posedge clk) disable iff (rst)
    (past_ok && !center_al && !$past(center_al) && active_period != '0 && count != '0)
      |-> (count < active_period)); // R5
endmodule

bind pwm_period_chan pwm_period_chan_chk #(
  .CNT_W(CNT_W), .UPD_W(UPD_W), .PRE_W(PRE_W), .PRE_MAX(PRE_MAX), .DIV_W(DIV_W)
) u_chk (
  .clk(clk), .rst(rst), .upd_we(upd_we), .upd_data(upd_data),
  .wp_soft(wp_soft), .wp_hard(wp_hard), .pre_sel(pre_sel), .src_sel(src_sel),
  .div_a(div_a), .div_b(div_b), .center_al(center_al), .duty(duty),
  .pwm_out(pwm_out), .count(count), .active_period(active_period),
  .update_pending(update_pending)
);

// File: tb/pwm_period_chan_tb.sv
module pwm_period_chan_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        upd_we = 1'b0;
  logic [23:0] upd_data = '0;
  logic        wp_soft = 1'b0, wp_hard = 1'b0;
  logic [3:0]  pre_sel = '0;
  logic [1:0]  src_sel = '0;
  logic [7:0]  div_a = 8'd1, div_b = 8'd1;
  logic        center_al = 1'b0;
  logic [15:0] duty = 16'd1;
  logic        pwm_out;
  logic [15:0] count, active_period;
  logic        update_pending;

  int errs = 0, checks = 0, cyc = 0;

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  pwm_period_chan u_dut (
    .clk(clk), .rst(rst), .upd_we(upd_we), .upd_data(upd_data),
    .wp_soft(wp_soft), .wp_hard(wp_hard), .pre_sel(pre_sel), .src_sel(src_sel),
    .div_a(div_a), .div_b(div_b), .center_al(center_al), .duty(duty),
    .pwm_out(pwm_out), .count(count), .active_period(active_period),
    .update_pending(update_pending)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic write_per(input logic [23:0] d);
    @(negedge clk);
    upd_we = 1'b1; upd_data = d;
    @(negedge clk);
    upd_we = 1'b0;
  endtask

  task automatic wait_xfer(output bit ok);
    ok = 1'b0;
    for (int i = 0; i < 20000; i++) begin
      if (!update_pending) begin ok = 1'b1; break; end
      @(negedge clk);
    end
  endtask

  task automatic wait_count(input logic [15:0] v);
    for (int i = 0; i < 20000; i++) begin
      @(negedge clk);
      if (count == v) break;
    end
  endtask

  task automatic next_rise(output int t);
    bit prev;
    prev = pwm_out;
    t = -1;
    for (int i = 0; i < 40000; i++) begin
      @(negedge clk);
      if (!prev && pwm_out) begin t = cyc; break; end
      prev = pwm_out;
    end
  endtask

  function automatic int exp_len(input int pre, input int src, input int da,
                                 input int db, input bit ctr, input int p);
    int x;
    x = 1 << pre;
    if (src == 1) x = x * da;
    if (src == 2) x = x * db;
    return ctr ? 2 * x * p : x * p;
  endfunction

  task automatic report;
    $display("  Result: errors=%0d of %0d checks", errs, checks);
  endtask

  initial begin
    #(4 * 190000);
    chk(1'b0, "watchdog", 0, 1);
    report();
    $finish;
  end

  initial begin
    bit ok;
    int t0, t1, t2, got, exp, lk;
    logic [15:0] held;
    lk = $urandom(32'd1234);

    idle(3);
    // R1: reset state
    chk(count == 0 && active_period == 0 && !update_pending && !pwm_out,
        "R1 reset state", {count, active_period} , 0);
    @(negedge clk) rst = 1'b0;
    idle(2);

    // R2: protected writes dropped
    wp_soft = 1'b1; write_per(24'd50); idle(1);
    chk(!update_pending, "R2 soft protect pending", update_pending, 0);
    wp_soft = 1'b0; wp_hard = 1'b1; write_per(24'd60); idle(20);
    chk(!update_pending, "R2 hard protect pending", update_pending, 0);
    chk(active_period == 0, "R2 hard protect period", active_period, 0);
    wp_hard = 1'b0;

    // R4: upper bits discarded
    write_per(24'hAB1234); wait_xfer(ok);
    chk(ok && active_period == 16'h1234, "R4 truncation", active_period, 16'h1234);

    // load period 10, edge aligned, no division
    write_per(24'd10); wait_xfer(ok);
    chk(ok && active_period == 10, "R10 initial load", active_period, 10);

    // R3 / R10 / R11 edge aligned
    wait_count(16'd3);
    write_per(24'd20);
    chk(active_period == 10, "R3 period not direct", active_period, 10);
    chk(update_pending, "R3 pending set", update_pending, 1);
    wait_xfer(ok);
    chk(ok && count == 0, "R11 edge transfer at zero", count, 0);
    chk(active_period == 20, "R10 edge transfer value", active_period, 20);

    // R10 / R11 symmetric
    center_al = 1'b1;
    write_per(24'd6); wait_xfer(ok);
    wait_count(16'd2);
    write_per(24'd9);
    chk(active_period == 6, "R3 center not direct", active_period, 6);
    wait_xfer(ok);
    chk(ok && count == 0, "R11 center transfer at zero", count, 0);
    chk(active_period == 9, "R10 center transfer value", active_period, 9);
    center_al = 1'b0;

    // R7: invalid prescaler freezes
    pre_sel = 4'd11; idle(2); held = count; idle(60);
    chk(count == held, "R7 pre 11 frozen", count, held);
    pre_sel = 4'd15; idle(2); held = count; idle(60);
    chk(count == held, "R7 pre 15 frozen", count, held);
    pre_sel = 4'd0;

    // R8: zero dividers freeze
    src_sel = 2'd1; div_a = 8'd0; idle(2); held = count; idle(40);
    chk(count == held, "R8 div_a zero frozen", count, held);
    src_sel = 2'd2; div_b = 8'd0; idle(2); held = count; idle(40);
    chk(count == held, "R8 div_b zero frozen", count, held);
    src_sel = 2'd0; div_a = 8'd1; div_b = 8'd1;

    // R9: output compare against count
    write_per(24'd16); wait_xfer(ok);
    for (int i = 0; i < 30; i++) begin
      @(negedge clk) duty = 16'($urandom % 20);
      @(negedge clk);
      chk(pwm_out == (count < duty), "R9 compare", pwm_out, count < duty);
    end
    duty = 16'd1;

    // R10 directed: 10 bit prescaler boundary, short period
    pre_sel = 4'd10; write_per(24'd2); wait_xfer(ok);
    next_rise(t0); next_rise(t1);
    chk(t1 - t0 == 2048, "R7 pre 10 length", t1 - t0, 2048);
    pre_sel = 4'd0;

    // R5 / R6 / R8 random mixes
    for (int k = 0; k < 14; k++) begin
      int pr, sr, da, db, p;
      bit ct;
      pr = $urandom % 4; sr = $urandom % 4; da = 1 + $urandom % 4;
      db = 1 + $urandom % 4; ct = 1'($urandom % 2); p = 2 + $urandom % 19;
      @(negedge clk);
      pre_sel = 4'(pr); src_sel = 2'(sr); div_a = 8'(da); div_b = 8'(db);
      center_al = ct;
      write_per(24'(p)); wait_xfer(ok);
      next_rise(t0); next_rise(t1); next_rise(t2);
      got = t2 - t1;
      exp = exp_len(pr, sr, da, db, ct, p);
      if (ct) chk(ok && got == exp, "R6 center length (R8 source mix)", got, exp);
      else    chk(ok && got == exp, "R5 edge length (R8 source mix)", got, exp);
    end

    report();
    $finish;
  end
endmodule